// File: doc/BRIEF.md
# Framed 16-Bit Serial Converter Port

This block is the serial slave side of a data converter. A host frames each exchange with an active-low frame signal and a serial clock. During one frame the block sends a 16-bit result word on its serial output, most significant bit first. It also collects a 16-bit control word from the serial input in the same bit order. The serial output has a separate enable so that a pad can drive it or leave it floating.

Framing can be pulsed, with the frame signal low for exactly one word. It can also be held low for good, in which case a bit counter alone splits the stream into words. The serial clock idles high. Output bits change on its falling edges and input bits are taken on its rising edges. Both the frame and serial clock inputs are already synchronised to the system clock, and the block detects their edges by comparing each with its value in the previous cycle. Raising the frame signal and dropping it again always restarts the word from its first bit.

Top module: `conv_serial_port`

## Requirements
- R1: After reset, sdo_oe is 0, sdo is 0, rx_valid is 0 and rx_word is all zeros.
- R2: sdo_oe becomes 1 one clock after frm_n is sampled low, and returns to 0 one clock after frm_n is sampled high. While sdo_oe is 0, sdo reads 0.
- R3: The first detected falling edge of sclk in a word drives a 0 onto sdo (the leading zero). Bit 15 of tx_word is never sent.
- R4: On the same first falling edge, tx_word is captured. The next 15 falling edges drive tx_word bits 14 down to 0 in that order. Each sdo change appears one clock after the falling edge is detected.
- R5: sdi is sampled on each detected rising edge of sclk while frm_n is low. The first rising edge of a word supplies rx_word bit 15 and the sixteenth supplies bit 0.
- R6: One clock after the sixteenth rising edge, rx_word holds the received word and rx_valid is 1 for exactly that one clock. rx_word changes at no other time.
- R7: If frm_n rises before the sixteenth rising edge, there is no rx_valid pulse, rx_word keeps its old value, and the next frame starts again at bit 15 on both lines.
- R8: With frm_n held low, the bit counters wrap from 15 to 0 with no idle clock. The next sclk falling edge starts a new word, which reloads tx_word and drives a new leading zero.
- R9: sclk edges while frm_n is high move neither counter and produce no rx_valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_n | input | 1 | Active-low frame signal, already synchronised |
| sclk | input | 1 | Serial clock, idles high, already synchronised |
| sdi | input | 1 | Serial data from the host |
| tx_word | input | 16 | Result word to send in the next word |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Drive enable for sdo, 1 while framed |
| rx_word | output | 16 | Last complete control word received |
| rx_valid | output | 1 | One-clock strobe marking a new rx_word |

## Verification
The assertions assume that sclk and frm_n change at most once per system clock. They also assume that two rising sclk edges are always at least two clocks apart, so a valid strobe can never run into a second one. The stimulus holds each serial clock phase for several system clocks and changes frm_n only while sclk is high, away from its edges. Random frames vary the words, the frame lengths, and whether framing is pulsed or held low.

// File: rtl/conv_sp_pkg.sv
package conv_sp_pkg;
  localparam int unsigned SP_WORD_W = 16;

  // width of a counter that indexes the bits of a word
  function automatic int unsigned sp_idx_w(input int unsigned w);
    return (w < 2) ? 1 : $clog2(w);
  endfunction
endpackage

// File: rtl/sp_edge_detect.sv
module sp_edge_detect #(
  parameter int unsigned     N    = 2,
  parameter logic [N-1:0]    IDLE = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= IDLE;
    else        lvl_q <= lvl;
  end

  for (genvar g = 0; g < N; g++) begin : g_edge
    assign rise[g] =  lvl[g] & ~lvl_q[g];
    assign fall[g] = ~lvl[g] &  lvl_q[g];
  end
endmodule

// File: rtl/sp_bit_counter.sv
module sp_bit_counter #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned CNT_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  output logic [CNT_W-1:0] cnt,
  output logic             first,
  output logic             last
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

  function automatic logic [CNT_W-1:0] next_idx(input logic [CNT_W-1:0] cur);
    return (cur == LAST_IDX) ? '0 : cur + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (step) cnt <= next_idx(cnt);
  end

  assign first = (cnt == '0);
  assign last  = (cnt == LAST_IDX);
endmodule

// File: rtl/sp_tx_shifter.sv
module sp_tx_shifter #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              fall,
  input  logic              first,
  input  logic [WORD_W-1:0] word_in,
  output logic              sdo
);
  logic [WORD_W-2:0] rest;

  // the top bit of every word on the line is a leading zero
  function automatic logic [WORD_W-1:0] line_word(input logic [WORD_W-1:0] w);
    return {1'b0, w[WORD_W-2:0]};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo  <= 1'b0;
      rest <= '0;
    end else if (!active) begin
      sdo  <= 1'b0;
    end else if (fall) begin
      if (first) begin
        {sdo, rest} <= line_word(word_in);
      end else begin
        sdo  <= rest[WORD_W-2];
        rest <= {rest[WORD_W-3:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/sp_rx_shifter.sv
module sp_rx_shifter #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              rise,
  input  logic              last,
  input  logic              sdi,
  output logic [WORD_W-1:0] word,
  output logic              valid
);
  logic [WORD_W-2:0] part;

  function automatic logic [WORD_W-1:0] finish_word(input logic [WORD_W-2:0] p,
                                                    input logic b);
    return {p, b};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part  <= '0;
      word  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (active && rise) begin
        if (last) begin
          word  <= finish_word(part, sdi);
          valid <= 1'b1;
        end else begin
          part  <= {part[WORD_W-3:0], sdi};
        end
      end
    end
  end
endmodule

// File: rtl/conv_serial_port.sv
module conv_serial_port #(
  parameter int unsigned WORD_W = conv_sp_pkg::SP_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic [WORD_W-1:0] tx_word,
  output logic              sdo,
  output logic              sdo_oe,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid
);
  localparam int unsigned CNT_W = conv_sp_pkg::sp_idx_w(WORD_W);

  // named internal events, used by the bound checker
  logic [1:0]       lvl_rise, lvl_fall;
  logic             sclk_rise, sclk_fall, frm_fall;
  logic             active;
  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic             tx_first, tx_last_unused, rx_first_unused, rx_last;
  logic             tx_start;
  logic             oe_q;

  sp_edge_detect #(.N(2), .IDLE(2'b11)) u_edges (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  ({frm_n, sclk}),
    .rise (lvl_rise),
    .fall (lvl_fall)
  );

  assign sclk_rise = lvl_rise[0];
  assign sclk_fall = lvl_fall[0];
  assign frm_fall  = lvl_fall[1];
  assign active    = ~frm_n;

  sp_bit_counter #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_tx_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (~active),
    .step (sclk_fall),
    .cnt  (tx_cnt),
    .first(tx_first),
    .last (tx_last_unused)
  );

  sp_bit_counter #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_rx_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (~active),
    .step (sclk_rise),
    .cnt  (rx_cnt),
    .first(rx_first_unused),
    .last (rx_last)
  );

  assign tx_start = active & sclk_fall & tx_first;

  sp_tx_shifter #(.WORD_W(WORD_W)) u_tx (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (active),
    .fall   (sclk_fall),
    .first  (tx_first),
    .word_in(tx_word),
    .sdo    (sdo)
  );

  sp_rx_shifter #(.WORD_W(WORD_W)) u_rx (
    .clk   (clk),
    .rst_n (rst_n),
    .active(active),
    .rise  (sclk_rise),
    .last  (rx_last),
    .sdi   (sdi),
    .word  (rx_word),
    .valid (rx_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_q <= 1'b0;
    else        oe_q <= active;
  end

  assign sdo_oe = oe_q;
endmodule

// File: rtl/conv_serial_port_chk.sv
module conv_serial_port_chk #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frm_n,
  input logic              sdo,
  input logic              sdo_oe,
  input logic [WORD_W-1:0] rx_word,
  input logic              rx_valid,
  input logic [CNT_W-1:0]  tx_cnt,
  input logic [CNT_W-1:0]  rx_cnt,
  input logic              tx_start,
  input logic              sclk_rise
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

  p_oe_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_n |=> sdo_oe);
  p_oe_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frm_n |=> (!sdo_oe && !sdo));
  p_lead_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !sdo);
  p_valid_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ($past(rx_cnt) == LAST_IDX && $past(sclk_rise) && !$past(frm_n)));
  p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  p_word_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_word));
  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frm_n |=> (tx_cnt == '0 && rx_cnt == '0));
  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (rx_cnt == '0));
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frm_n) |-> !rx_valid);
endmodule

bind conv_serial_port conv_serial_port_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .frm_n    (frm_n),
  .sdo      (sdo),
  .sdo_oe   (sdo_oe),
  .rx_word  (rx_word),
  .rx_valid (rx_valid),
  .tx_cnt   (tx_cnt),
  .rx_cnt   (rx_cnt),
  .tx_start (tx_start),
  .sclk_rise(sclk_rise)
);

// File: tb/test_conv_serial_port.sv
module test_conv_serial_port;
  localparam int CLK_P = 10;
  localparam int HALF  = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frm_n = 1'b1;
  logic        sclk = 1'b1;
  logic        sdi = 1'b0;
  logic [15:0] tx_word = '0;
  logic        sdo, sdo_oe, rx_valid;
  logic [15:0] rx_word;

  int checks = 0;
  int fails  = 0;
  int vcount = 0;
  int dbl    = 0;
  logic [15:0] last_rx = '0;
  logic        prev_v = 1'b0;
  bit          done = 1'b0;

  conv_serial_port i_conv_serial_port (
    .clk(clk), .rst_n(rst_n), .frm_n(frm_n), .sclk(sclk), .sdi(sdi),
    .tx_word(tx_word), .sdo(sdo), .sdo_oe(sdo_oe), .rx_word(rx_word),
    .rx_valid(rx_valid)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) begin
    if (rx_valid) begin
      vcount++;
      last_rx = rx_word;
      if (prev_v) dbl++;
    end
    prev_v = rx_valid;
  end

  // expected line bit i of a word (i = 0 is the first bit sent)
  function automatic logic exp_bit(input logic [15:0] w, input int i);
    if (i == 0) return 1'b0;
    return w[15-i];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // nbits serial clock cycles of one word; frame level handled by caller
  task automatic shift_word(input logic [15:0] tx, input logic [15:0] rx, input int nbits,
                            input string req);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0;
      if (i == 0) tx_word = tx;
      wait_n(HALF);
      check(req, {31'd0, sdo}, {31'd0, exp_bit(tx, i)});
      sdi  = rx[15-i];
      sclk = 1'b1;
      wait_n(HALF);
    end
  endtask

  task automatic pulsed_frame(input logic [15:0] tx, input logic [15:0] rx);
    int v0;
    v0 = vcount;
    frm_n = 1'b0;
    wait_n(2);
    check("R2 oe on", {31'd0, sdo_oe}, 32'd1);
    shift_word(tx, rx, 16, "R4 sdo bit");
    wait_n(1);
    check("R6 one strobe", vcount - v0, 1);
    check("R5 rx word", {16'd0, last_rx}, {16'd0, rx});
    frm_n = 1'b1;
    wait_n(2);
    check("R2 oe off", {30'd0, sdo_oe, sdo}, 32'd0);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] tx, rx, keep;
    int v0;
    void'($urandom(32'h5eed));
    wait_n(3);
    check("R1 reset outs", {14'd0, sdo_oe, sdo, rx_valid, 15'd0}, 32'd0);
    check("R1 reset word", {16'd0, rx_word}, 32'd0);
    rst_n = 1'b1;
    wait_n(2);

    // R3: tx bit 15 set must still go out as a leading zero
    pulsed_frame(16'hFFFF, 16'hA5C3);
    pulsed_frame(16'h8001, 16'h0001);

    // R9: serial clock toggles while unframed
    v0 = vcount;
    for (int k = 0; k < 5; k++) begin
      sclk = 1'b0; sdi = 1'b1; wait_n(HALF);
      sclk = 1'b1; wait_n(HALF);
    end
    check("R9 no strobe unframed", vcount - v0, 0);
    pulsed_frame(16'h1234, 16'h8000);

    // R7: short frame, then a full one realigns
    keep = last_rx;
    v0 = vcount;
    frm_n = 1'b0; wait_n(2);
    shift_word(16'h7FFF, 16'hFFFF, 9, "R7 partial sdo");
    frm_n = 1'b1; wait_n(3);
    check("R7 no strobe", vcount - v0, 0);
    check("R7 word kept", {16'd0, rx_word}, {16'd0, keep});
    pulsed_frame(16'h4C2B, 16'h3C5A);

    // random pulsed frames
    for (int n = 0; n < 20; n++) begin
      tx = 16'($urandom);
      rx = 16'($urandom);
      pulsed_frame(tx, rx);
    end

    // R8: frame held low, back-to-back words
    frm_n = 1'b0; wait_n(2);
    for (int n = 0; n < 6; n++) begin
      tx = 16'($urandom) | 16'h8000;
      rx = 16'($urandom);
      v0 = vcount;
      shift_word(tx, rx, 16, "R8 held sdo");
      wait_n(1);
      check("R8 held strobe", vcount - v0, 1);
      check("R8 held word", {16'd0, last_rx}, {16'd0, rx});
    end
    check("R8 oe held", {31'd0, sdo_oe}, 32'd1);
    frm_n = 1'b1; wait_n(3);
    check("R6 strobe width", dbl, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule